// File: doc/BRIEF.md
# UART Interrupt Priority Encoder

This block gathers every interrupt condition of an enhanced UART and reports the one with the highest priority as a 6-bit status code. Each condition is gated by its own enable bit. A single interrupt line is also driven, and it is high while any enabled condition is pending. Software reads the code to find out why the line went high. The read strobes for the status, line-status and modem-status registers then retire the matching sources.

The block keeps sticky pending bits for four sources: line-status errors, modem changes, transmit-empty and special-character/flow-control detection. Error, modem-delta and match inputs are one-cycle event strobes from the neighbouring logic. The receive-data, receive time-out and CTS/RTS-change sources are level inputs and are evaluated directly. A higher level always hides a lower one in the code, but a hidden source stays pending.

Top module: `uart_irq_encoder`

## Requirements
- R1: The status code is one of: none 000001, line-status error 000110, receive data 000100, receive time-out 001100, transmit-empty 000010, modem change 000000, special character 010000, CTS/RTS change 100000. Among pending enabled sources, priority falls in exactly that order, so the line-status error has the highest priority.
- R2: Code bit 0 is 1 exactly when nothing enabled is pending, and `irq` is its inverse.
- R3: The special-character and CTS/RTS sources appear in neither the code nor `irq` unless `enh_mode` is 1. A special-character pending bit is kept while it is suppressed.
- R4: A line-status error pulse on any bit of `lsr_err` sets a sticky bit that holds until `lsr_rd`. Its report is gated by `ien[2]`.
- R5: Receive data is reported while `rx_lvl` is strictly greater than `rx_trig`. Receive time-out is reported only while `rx_tmo` and `fifo_en` are both 1. Both are gated by `ien[0]`.
- R6: Transmit-empty is set on the cycle after its condition turns true, where the condition is `tx_lvl < tx_trig`. It is cleared by an `isr_rd` that returns 000010, or as soon as the condition is false. It is gated by `ien[1]`.
- R7: When `ext_trig` is 1 and `tx_trig` is 0, the transmit-empty condition is instead: `tx_lvl` is 0 and `tsr_empty` is 1 and `line_idle` is 1.
- R8: A pulse on any bit of `msr_delta` sets a sticky modem-change bit that holds until `msr_rd`. It is gated by `ien[3]`.
- R9: In enhanced mode the special-character bit is set by any of these: `xoff_hit` while `inband_en` is 1, `xoff2_hit` while `spcdet_en` is 1, or `spc_hit` while `nine_bit` is 1. It is cleared by an `isr_rd` that returns 010000. It is gated by `ien[4]`.
- R10: An `isr_rd` clears only the source whose code it returns. Any other pending source is unchanged.
- R11: Disabling a source hides it but does not discard a sticky pending bit. The CTS/RTS change source is gated by `ien[5]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enh_mode | input | 1 | Enhanced mode enable |
| fifo_en | input | 1 | FIFOs enabled |
| nine_bit | input | 1 | 9-bit character mode |
| ext_trig | input | 1 | Extended trigger levels enabled |
| inband_en | input | 1 | In-band flow control enabled |
| spcdet_en | input | 1 | Special-character detection enabled |
| ien | input | 6 | Source enables (bit map in R4 to R11) |
| lsr_err | input | 4 | Line-status error event strobes |
| rx_lvl | input | LW | Receive FIFO fill level |
| rx_trig | input | LW | Receive trigger level |
| rx_tmo | input | 1 | Receive time-out condition |
| tx_lvl | input | LW | Transmit FIFO fill level |
| tx_trig | input | LW | Transmit trigger level |
| tsr_empty | input | 1 | Transmit shift register empty |
| line_idle | input | 1 | Serial output back at idle mark |
| msr_delta | input | 4 | Modem delta event strobes |
| cts_rts_chg | input | 1 | CTS/RTS change condition |
| xoff_hit | input | 1 | Xoff match strobe |
| xoff2_hit | input | 1 | Xoff2 match strobe |
| spc_hit | input | 1 | Special character 1 to 4 match strobe |
| isr_rd | input | 1 | Status register read strobe |
| lsr_rd | input | 1 | Line-status register read strobe |
| msr_rd | input | 1 | Modem-status register read strobe |
| isr_code | output | 6 | Highest-priority status code |
| irq | output | 1 | Interrupt line |

## Verification
The hardest state to reach is several sticky sources pending together, with the highest one being retired by a read. This is the only way to show that a status read clears just the reported source while a lower one survives underneath. The stimulus raises a line-status error and a special-character match together. It then issues a status read while the error is shown, confirms that the special-character code surfaces only after the line-status read, and retires that code with a second status read. The zero-trigger transmit rule is approached from a false condition, and the three idle inputs are completed one at a time, so each step shows that the bit stays clear until the last one.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  typedef logic [5:0] isr_code_t;

  localparam isr_code_t C_NONE = 6'b000001;
  localparam isr_code_t C_RLS  = 6'b000110;
  localparam isr_code_t C_RDA  = 6'b000100;
  localparam isr_code_t C_RTO  = 6'b001100;
  localparam isr_code_t C_THR  = 6'b000010;
  localparam isr_code_t C_MSC  = 6'b000000;
  localparam isr_code_t C_SPC  = 6'b010000;
  localparam isr_code_t C_FLW  = 6'b100000;

  localparam int NSRC = 7;

  // enable bit positions
  localparam int IE_RX  = 0;
  localparam int IE_TX  = 1;
  localparam int IE_LS  = 2;
  localparam int IE_MS  = 3;
  localparam int IE_SPC = 4;
  localparam int IE_FLW = 5;

  function automatic isr_code_t src_code(input int idx);
    case (idx)
      0:       return C_RLS;
      1:       return C_RDA;
      2:       return C_RTO;
      3:       return C_THR;
      4:       return C_MSC;
      5:       return C_SPC;
      6:       return C_FLW;
      default: return C_NONE;
    endcase
  endfunction
endpackage

// File: rtl/uirq_sticky.sv
module uirq_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  logic pend_d;

  always_comb begin
    pend_d = pend_o;
    if (clr_i) pend_d = 1'b0;
    if (set_i) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_o <= 1'b0;
    else        pend_o <= pend_d;
  end

  AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> pend_o); // R9
  AST_STICKY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !pend_o); // R4
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(pend_o)); // R11
endmodule

// File: rtl/uirq_txe.sv
module uirq_txe #(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_trig,
  input  logic [LW-1:0] tx_lvl,
  input  logic [LW-1:0] tx_trig,
  input  logic          tsr_empty,
  input  logic          line_idle,
  input  logic          clr_rd,
  output logic          pend_o
);
  logic zero_rule;
  logic cond;
  logic cond_q;
  logic rise;
  logic pend_d;

  always_comb begin
    zero_rule = ext_trig && (tx_trig == '0);
    if (zero_rule) cond = (tx_lvl == '0) && tsr_empty && line_idle;
    else           cond = tx_lvl < tx_trig;
    rise = cond && !cond_q;
  end

  always_comb begin
    pend_d = pend_o;
    if (clr_rd || !cond) pend_d = 1'b0;
    if (rise)            pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_q <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      cond_q <= cond;
      pend_o <= pend_d;
    end
  end

  AST_TXE_ZERO_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_rule && !(tsr_empty && line_idle && tx_lvl == '0)) |=> !pend_o); // R7
  AST_TXE_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!zero_rule && !(tx_lvl < tx_trig)) |=> !pend_o); // R6
endmodule

// File: rtl/uirq_prio.sv
module uirq_prio
  import uirq_pkg::*;
(
  input  logic [NSRC-1:0] req_i,
  output isr_code_t       code_o,
  output logic            any_o
);
  always_comb begin
    code_o = C_NONE;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req_i[i]) code_o = src_code(i);
    end
    any_o = |req_i;
  end

  always_comb begin
    assert (any_o || code_o == C_NONE); // R2
  end
endmodule

// File: rtl/uart_irq_encoder.sv
module uart_irq_encoder
  import uirq_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enh_mode,
  input  logic          fifo_en,
  input  logic          nine_bit,
  input  logic          ext_trig,
  input  logic          inband_en,
  input  logic          spcdet_en,
  input  logic [5:0]    ien,
  input  logic [3:0]    lsr_err,
  input  logic [LW-1:0] rx_lvl,
  input  logic [LW-1:0] rx_trig,
  input  logic          rx_tmo,
  input  logic [LW-1:0] tx_lvl,
  input  logic [LW-1:0] tx_trig,
  input  logic          tsr_empty,
  input  logic          line_idle,
  input  logic [3:0]    msr_delta,
  input  logic          cts_rts_chg,
  input  logic          xoff_hit,
  input  logic          xoff2_hit,
  input  logic          spc_hit,
  input  logic          isr_rd,
  input  logic          lsr_rd,
  input  logic          msr_rd,
  output logic [5:0]    isr_code,
  output logic          irq
);
  logic            ls_pend;
  logic            ms_pend;
  logic            spc_pend;
  logic            thr_pend;
  logic            spc_set;
  logic            clr_thr;
  logic            clr_spc;
  logic [NSRC-1:0] req;
  isr_code_t       code;
  logic            any;

  always_comb begin
    spc_set = enh_mode && ((xoff_hit && inband_en) ||
                           (xoff2_hit && spcdet_en) ||
                           (spc_hit && nine_bit));
    clr_thr = isr_rd && (code == C_THR);
    clr_spc = isr_rd && (code == C_SPC);
  end

  uirq_sticky u_ls (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (|lsr_err),
    .clr_i  (lsr_rd),
    .pend_o (ls_pend)
  );

  uirq_sticky u_ms (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (|msr_delta),
    .clr_i  (msr_rd),
    .pend_o (ms_pend)
  );

  uirq_sticky u_spc (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (spc_set),
    .clr_i  (clr_spc),
    .pend_o (spc_pend)
  );

  uirq_txe #(.LW(LW)) u_txe (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_trig  (ext_trig),
    .tx_lvl    (tx_lvl),
    .tx_trig   (tx_trig),
    .tsr_empty (tsr_empty),
    .line_idle (line_idle),
    .clr_rd    (clr_thr),
    .pend_o    (thr_pend)
  );

  always_comb begin
    req[0] = ls_pend && ien[IE_LS];
    req[1] = (rx_lvl > rx_trig) && ien[IE_RX];
    req[2] = fifo_en && rx_tmo && ien[IE_RX];
    req[3] = thr_pend && ien[IE_TX];
    req[4] = ms_pend && ien[IE_MS];
    req[5] = enh_mode && spc_pend && ien[IE_SPC];
    req[6] = enh_mode && cts_rts_chg && ien[IE_FLW];
  end

  uirq_prio u_prio (
    .req_i  (req),
    .code_o (code),
    .any_o  (any)
  );

  assign isr_code = code;
  assign irq      = any;

  AST_IRQ_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
    irq == !isr_code[0]); // R2
  AST_RLS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_pend && ien[IE_LS]) |-> isr_code == C_RLS); // R1
  AST_NO_ENH_HI: assert property (@(posedge clk) disable iff (!rst_n)
    !enh_mode |-> (isr_code != C_SPC && isr_code != C_FLW)); // R3
  AST_RD_OTHER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_rd && code == C_RLS && spc_pend && !lsr_rd) |=> (ls_pend && spc_pend)); // R10
endmodule

// File: tb/sim_uart_irq_encoder.sv
module sim_uart_irq_encoder;
  localparam int LW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          enh_mode, fifo_en, nine_bit, ext_trig, inband_en, spcdet_en;
  logic [5:0]    ien;
  logic [3:0]    lsr_err, msr_delta;
  logic [LW-1:0] rx_lvl, rx_trig, tx_lvl, tx_trig;
  logic          rx_tmo, tsr_empty, line_idle, cts_rts_chg;
  logic          xoff_hit, xoff2_hit, spc_hit, isr_rd, lsr_rd, msr_rd;
  logic [5:0]    isr_code;
  logic          irq;

  int nchk = 0;
  int nbad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_irq_encoder u0 (.*);

  typedef struct packed {
    logic [5:0]    ien;
    logic          enh;
    logic          fen;
    logic [LW-1:0] rxl;
    logic [LW-1:0] rxt;
    logic          tmo;
    logic          cts;
    logic [5:0]    exp_code;
    logic          exp_irq;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VT [NV] = '{
    '{6'h3F, 1'b1, 1'b1, 8'd10, 8'd8, 1'b1, 1'b1, 6'b000100, 1'b1},
    '{6'h3F, 1'b1, 1'b1, 8'd8,  8'd8, 1'b1, 1'b1, 6'b001100, 1'b1},
    '{6'h3F, 1'b1, 1'b1, 8'd8,  8'd8, 1'b0, 1'b1, 6'b100000, 1'b1},
    '{6'h3F, 1'b0, 1'b1, 8'd8,  8'd8, 1'b0, 1'b1, 6'b000001, 1'b0},
    '{6'h3F, 1'b1, 1'b0, 8'd0,  8'd8, 1'b1, 1'b0, 6'b000001, 1'b0},
    '{6'h3E, 1'b1, 1'b1, 8'd10, 8'd8, 1'b1, 1'b0, 6'b000001, 1'b0},
    '{6'h3E, 1'b1, 1'b1, 8'd10, 8'd8, 1'b1, 1'b1, 6'b100000, 1'b1},
    '{6'h01, 1'b1, 1'b1, 8'd9,  8'd8, 1'b0, 1'b1, 6'b000100, 1'b1},
    '{6'h00, 1'b1, 1'b1, 8'd9,  8'd8, 1'b1, 1'b1, 6'b000001, 1'b0}
  };

  task automatic chk(input string req, input logic [5:0] exp_code, input logic exp_irq);
    nchk++;
    if (isr_code !== exp_code || irq !== exp_irq) begin
      nbad++;
      $display("FAIL %s: code=%b irq=%b expected code=%b irq=%b",
               req, isr_code, irq, exp_code, exp_irq);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // one-cycle strobe helpers: drive on negedge, remove on next negedge
  task automatic pulse_isr();  isr_rd = 1; tick(); isr_rd = 0; endtask
  task automatic pulse_lsr();  lsr_rd = 1; tick(); lsr_rd = 0; endtask
  task automatic pulse_msr();  msr_rd = 1; tick(); msr_rd = 0; endtask

  initial begin
    rst_n = 0; enh_mode = 0; fifo_en = 0; nine_bit = 0; ext_trig = 0;
    inband_en = 0; spcdet_en = 0; ien = 0; lsr_err = 0; msr_delta = 0;
    rx_lvl = 0; rx_trig = 8; rx_tmo = 0; tx_lvl = 8'd100; tx_trig = 8'd16;
    tsr_empty = 0; line_idle = 0; cts_rts_chg = 0; xoff_hit = 0;
    xoff2_hit = 0; spc_hit = 0; isr_rd = 0; lsr_rd = 0; msr_rd = 0;
    tick(); tick();
    chk("R2 reset", 6'b000001, 1'b0);
    rst_n = 1;
    tick();
    chk("R2 after reset", 6'b000001, 1'b0);

    // table walk: level sources only (R1 R3 R5 R11)
    for (int i = 0; i < NV; i++) begin
      ien = VT[i].ien; enh_mode = VT[i].enh; fifo_en = VT[i].fen;
      rx_lvl = VT[i].rxl; rx_trig = VT[i].rxt; rx_tmo = VT[i].tmo;
      cts_rts_chg = VT[i].cts;
      #1;
      chk($sformatf("R1/R3/R5/R11 vector %0d", i), VT[i].exp_code, VT[i].exp_irq);
      tick();
    end
    rx_lvl = 0; rx_tmo = 0; cts_rts_chg = 0; enh_mode = 0; ien = 6'h00;
    tick();

    // R4: line status sticky, masked then revealed
    lsr_err = 4'b0010; tick(); lsr_err = 0;
    chk("R4 masked", 6'b000001, 1'b0);
    ien = 6'h04; #1;
    chk("R11 revealed", 6'b000110, 1'b1);
    tick(); tick();
    chk("R4 held", 6'b000110, 1'b1);
    pulse_lsr();
    chk("R4 cleared by lsr read", 6'b000001, 1'b0);

    // R8: modem sticky
    ien = 6'h0F;
    msr_delta = 4'b1000; tick(); msr_delta = 0;
    chk("R8 set", 6'b000000, 1'b1);
    pulse_isr();
    chk("R10 isr read keeps modem", 6'b000000, 1'b1);
    pulse_msr();
    chk("R8 cleared by msr read", 6'b000001, 1'b0);

    // R6: transmit-empty
    tx_lvl = 8'd4; tick();
    chk("R6 set below trigger", 6'b000010, 1'b1);
    msr_delta = 4'b0001; tick(); msr_delta = 0;
    chk("R1 thr over modem", 6'b000010, 1'b1);
    pulse_isr();
    chk("R6 cleared by read, modem shown", 6'b000000, 1'b1);
    pulse_msr();
    chk("R6 stays clear while level low", 6'b000001, 1'b0);
    tx_lvl = 8'd20; tick();
    tx_lvl = 8'd3; tick();
    chk("R6 set again", 6'b000010, 1'b1);
    lsr_err = 4'b0100; tick(); lsr_err = 0;
    chk("R1 line status over thr", 6'b000110, 1'b1);
    pulse_lsr();
    chk("R4 cleared, thr shown", 6'b000010, 1'b1);
    tx_lvl = 8'd20; tick();
    chk("R6 cleared by fill", 6'b000001, 1'b0);

    // R7: zero trigger rule
    ext_trig = 1; tx_trig = 8'd0; tx_lvl = 8'd0; tick(); tick();
    chk("R7 shifter busy", 6'b000001, 1'b0);
    tsr_empty = 1; tick(); tick();
    chk("R7 line not idle", 6'b000001, 1'b0);
    line_idle = 1; tick();
    chk("R7 all idle", 6'b000010, 1'b1);
    tx_lvl = 8'd5; tick();
    chk("R7 cleared by data", 6'b000001, 1'b0);
    ext_trig = 0; tx_trig = 8'd16; tx_lvl = 8'd100; tick();

    // R9: special characters
    ien = 6'h1F; enh_mode = 1;
    xoff_hit = 1; tick(); xoff_hit = 0;
    chk("R9 xoff without flow enable", 6'b000001, 1'b0);
    inband_en = 1; xoff_hit = 1; tick(); xoff_hit = 0;
    chk("R9 xoff set", 6'b010000, 1'b1);
    pulse_isr();
    chk("R9 cleared by read", 6'b000001, 1'b0);
    xoff2_hit = 1; tick(); xoff2_hit = 0;
    chk("R9 xoff2 without detect", 6'b000001, 1'b0);
    spc_hit = 1; nine_bit = 1; tick(); spc_hit = 0;
    chk("R9 special in 9-bit", 6'b010000, 1'b1);
    enh_mode = 0; #1;
    chk("R3 suppressed", 6'b000001, 1'b0);
    pulse_isr();
    enh_mode = 1; #1;
    chk("R3 kept while suppressed", 6'b010000, 1'b1);

    // R10: read of level 1 leaves level 5
    lsr_err = 4'b1000; tick(); lsr_err = 0;
    chk("R1 line status over special", 6'b000110, 1'b1);
    pulse_isr();
    chk("R10 line status stays", 6'b000110, 1'b1);
    pulse_lsr();
    chk("R10 special survives", 6'b010000, 1'b1);
    pulse_isr();
    chk("R9 final clear", 6'b000001, 1'b0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end
endmodule